// File: doc/BRIEF.md
# XOR-Hashed Direct-Mapped Set Lookup

This block is the tag lookup stage of a direct-mapped cache with a power-of-two set count. It turns a 32-bit byte address into a set index, keeps one tag and one valid bit per set, and reports hit or miss one cycle after a request. The index is built from the block address, which is the address with the two byte-offset bits removed. By default the index is the low block-address bits. This is the block address modulo the set count, done without any divider.

When `hashEn` is high, the six address bits just above the index field are XOR-folded into the index. Large objects that sit on the same power-of-two alignment would otherwise all land in one set. With the fold they spread across the sets.

The stored tag is the whole upper address above the unhashed index field. A hashed index can therefore never produce a false match. A fill request writes the tag at the computed set and marks it valid. A flush clears every valid bit in one cycle.

Top module: `hashed_set_lookup`

## Requirements
- R1: With `hashEn` low, the set index reported on `rspIndex` is `reqAddr[7:2]`. Address bits 1:0 have no effect on the index or on hit.
- R2: With `hashEn` high, the set index is `reqAddr[7:2] ^ reqAddr[13:8]`.
- R3: `rspValid` is high in exactly the cycle after a cycle with `reqValid` high, and low otherwise.
- R4: `rspHit` is 1 only if the selected set is valid and its stored tag equals `reqAddr[31:8]`. A request with the same set but a different tag misses.
- R5: A fill writes `fillAddr[31:8]` as the tag at the set computed from `fillAddr` and the current `hashEn`, and marks that set valid. A later lookup of the same address then hits.
- R6: A fill to a set that already holds a line replaces that line. The old address then misses and the new one hits.
- R7: A flush clears all valid bits. A fill in the same cycle as a flush is dropped.
- R8: After reset all sets are invalid, and `rspValid` and `rspHit` are 0.
- R9: A lookup sees the array as it was before any fill issued in the same cycle.
- R10: With hashing on, addresses that differ only in bits 13:8 occupy distinct sets and stay resident together.
- R11: `rspHit` is never high while `rspValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hashEn | input | 1 | Selects XOR-folded set index for both lookups and fills |
| reqValid | input | 1 | Lookup request strobe |
| reqAddr | input | 32 | Lookup byte address |
| fillValid | input | 1 | Fill request strobe |
| fillAddr | input | 32 | Fill byte address |
| flush | input | 1 | Invalidate all sets (wins over a same-cycle fill) |
| rspValid | output | 1 | Lookup result valid, one cycle after request |
| rspHit | output | 1 | Lookup hit |
| rspIndex | output | 6 | Set index used by the lookup |

## Verification
The assertions take for granted that `hashEn` has the same value for a fill and for any later lookup of that address. A line filled under one index mapping cannot be found under the other. They also assume the strobes are driven to known levels during reset.

The stimulus holds `hashEn` fixed within each phase and flushes the array whenever the mode changes. Every fill and lookup therefore uses the same mapping. The bench also keeps a behavioural tag/valid model that is computed from the index formulas alone.

// File: rtl/hsl_pkg.sv
package hsl_pkg;

  // Strobes sent from the control module to the datapath
  typedef struct packed {
    logic lookup;
    logic fill;
    logic flush;
  } hslStrobe_t;

endpackage

// File: rtl/hsl_index.sv
module hsl_index #(
  parameter int ADDR_W       = 32,
  parameter int OFFSET_W     = 2,
  parameter int SETS         = 64,
  parameter bit HASH_SUPPORT = 1'b1,
  localparam int IDX_W       = $clog2(SETS),
  localparam int TAG_W       = ADDR_W - OFFSET_W - IDX_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              hashEn,
  output logic [IDX_W-1:0]  setIdx,
  output logic [TAG_W-1:0]  tag
);

  localparam int TAG_LSB = OFFSET_W + IDX_W;

  logic [IDX_W-1:0] baseIdx;
  logic             offsetUnused;

  // Block address modulo a power-of-two set count is a plain bit slice
  assign baseIdx      = addr[OFFSET_W +: IDX_W];
  assign tag          = addr[ADDR_W-1:TAG_LSB];
  assign offsetUnused = ^addr[OFFSET_W-1:0];

  generate
    if (HASH_SUPPORT) begin : g_hash
      logic [IDX_W-1:0] foldBits;
      assign foldBits = addr[TAG_LSB +: IDX_W];
      assign setIdx   = hashEn ? (baseIdx ^ foldBits) : baseIdx;
    end else begin : g_plain
      logic hashUnused;
      assign hashUnused = hashEn;
      assign setIdx     = baseIdx;
    end
  endgenerate

endmodule

// File: rtl/hsl_ctrl.sv
module hsl_ctrl
  import hsl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reqValid,
  input  logic       fillValid,
  input  logic       flush,
  output hslStrobe_t strobe,
  output logic       rspValid
);

  // Flush has priority: a fill in the same cycle is dropped
  always_comb begin
    strobe.lookup = reqValid;
    strobe.flush  = flush;
    strobe.fill   = fillValid && !flush;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rspValid <= 1'b0;
    else        rspValid <= reqValid;
  end

  assert_rsp_follows_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> rspValid);

  assert_rsp_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> !rspValid);

endmodule

// File: rtl/hsl_datapath.sv
module hsl_datapath
  import hsl_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFFSET_W = 2,
  parameter int SETS     = 64,
  localparam int IDX_W   = $clog2(SETS),
  localparam int TAG_W   = ADDR_W - OFFSET_W - IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  hslStrobe_t       strobe,
  input  logic [IDX_W-1:0] reqIdx,
  input  logic [TAG_W-1:0] reqTag,
  input  logic [IDX_W-1:0] fillIdx,
  input  logic [TAG_W-1:0] fillTag,
  output logic             rspHit,
  output logic [IDX_W-1:0] rspIndex
);

  logic [SETS-1:0]  validBits;
  logic [TAG_W-1:0] tagMem [SETS];
  logic             tagMatch;

  assign tagMatch = validBits[reqIdx] && (tagMem[reqIdx] == reqTag);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      validBits <= '0;
    end else if (strobe.flush) begin
      validBits <= '0;
    end else if (strobe.fill) begin
      validBits[fillIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.fill) tagMem[fillIdx] <= fillTag;
  end

  // The compare reads the array as it stood before this edge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rspHit   <= 1'b0;
      rspIndex <= '0;
    end else begin
      rspHit   <= strobe.lookup && tagMatch;
      if (strobe.lookup) rspIndex <= reqIdx;
    end
  end

  assert_reset_clears_R8: assert property (@(posedge clk)
    !rst_n |=> (validBits == '0) && !rspHit);

  assert_flush_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.flush |=> (validBits == '0));

  assert_fill_sets_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.fill |=> validBits[$past(fillIdx)]);

  assert_fill_then_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.lookup && $past(strobe.fill) && !$past(strobe.flush) &&
     reqIdx == $past(fillIdx) && reqTag == $past(fillTag)) |=> rspHit);

  assert_replaced_tag_misses_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.lookup && $past(strobe.fill) && !$past(strobe.flush) &&
     reqIdx == $past(fillIdx) && reqTag != $past(fillTag)) |=> !rspHit);

  assert_hit_needs_lookup_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rspHit |-> $past(strobe.lookup));

endmodule

// File: rtl/hashed_set_lookup.sv
module hashed_set_lookup
  import hsl_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int OFFSET_W     = 2,
  parameter int SETS         = 64,
  parameter bit HASH_SUPPORT = 1'b1,
  localparam int IDX_W       = $clog2(SETS),
  localparam int TAG_W       = ADDR_W - OFFSET_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hashEn,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              fillValid,
  input  logic [ADDR_W-1:0] fillAddr,
  input  logic              flush,
  output logic              rspValid,
  output logic              rspHit,
  output logic [IDX_W-1:0]  rspIndex
);

  hslStrobe_t       strobe;
  logic [IDX_W-1:0] reqIdx, fillIdx;
  logic [TAG_W-1:0] reqTag, fillTag;

  hsl_index #(.ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W), .SETS(SETS), .HASH_SUPPORT(HASH_SUPPORT))
    reqIndex_i (.addr(reqAddr), .hashEn(hashEn), .setIdx(reqIdx), .tag(reqTag));

  hsl_index #(.ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W), .SETS(SETS), .HASH_SUPPORT(HASH_SUPPORT))
    fillIndex_i (.addr(fillAddr), .hashEn(hashEn), .setIdx(fillIdx), .tag(fillTag));

  hsl_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .fillValid(fillValid),
    .flush(flush), .strobe(strobe), .rspValid(rspValid)
  );

  hsl_datapath #(.ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W), .SETS(SETS)) datapath_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .reqIdx(reqIdx), .reqTag(reqTag), .fillIdx(fillIdx), .fillTag(fillTag),
    .rspHit(rspHit), .rspIndex(rspIndex)
  );

  assert_plain_index_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !hashEn) |=> rspIndex == $past(reqAddr[OFFSET_W +: IDX_W]));

  generate
    if (HASH_SUPPORT) begin : g_hashChk
      assert_folded_index_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reqValid && hashEn) |=> rspIndex ==
          $past(reqAddr[OFFSET_W +: IDX_W] ^ reqAddr[OFFSET_W+IDX_W +: IDX_W]));
    end
  endgenerate

  assert_hit_only_when_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rspHit |-> rspValid);

endmodule

// File: tb/hashed_set_lookup_tb.sv
module hashed_set_lookup_tb_top;

  localparam int SETS = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hashEn = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        fillValid = 1'b0;
  logic [31:0] fillAddr = '0;
  logic        flush = 1'b0;
  logic        rspValid, rspHit;
  logic [5:0]  rspIndex;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 1'b0;

  bit          mValid [SETS];
  logic [23:0] mTag   [SETS];
  logic [31:0] lcg = 32'h1234_5678;

  hashed_set_lookup dut_i (
    .clk(clk), .rst_n(rst_n), .hashEn(hashEn), .reqValid(reqValid), .reqAddr(reqAddr),
    .fillValid(fillValid), .fillAddr(fillAddr), .flush(flush),
    .rspValid(rspValid), .rspHit(rspHit), .rspIndex(rspIndex)
  );

  always #10ns clk = ~clk;

  function automatic int expIdx(logic [31:0] a, bit h);
    int b = int'((a >> 2) % 64);
    int f = int'((a >> 8) % 64);
    return h ? (b ^ f) : b;
  endfunction

  task automatic chk(string rq, string what, longint act, longint exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic modelFlush();
    for (int i = 0; i < SETS; i++) mValid[i] = 1'b0;
  endtask

  // Tasks enter and leave at a falling edge
  task automatic doFill(logic [31:0] a);
    int e = expIdx(a, hashEn);
    fillValid = 1'b1; fillAddr = a;
    @(posedge clk); @(negedge clk);
    fillValid = 1'b0;
    mValid[e] = 1'b1; mTag[e] = a[31:8];
  endtask

  task automatic doFlush();
    flush = 1'b1;
    @(posedge clk); @(negedge clk);
    flush = 1'b0;
    modelFlush();
  endtask

  task automatic doLookup(logic [31:0] a, string rq);
    int  e = expIdx(a, hashEn);
    bit  eh = mValid[e] && (mTag[e] == a[31:8]);
    reqValid = 1'b1; reqAddr = a;
    @(posedge clk); @(negedge clk);
    reqValid = 1'b0;
    chk("R3", "rspValid after request", rspValid, 1);
    chk(hashEn ? "R2" : "R1", "rspIndex", rspIndex, e);
    chk(rq, "rspHit", rspHit, eh);
  endtask

  initial begin
    modelFlush();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8", "rspValid in reset", rspValid, 0);
    chk("R8", "rspHit in reset", rspHit, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8", "rspValid after reset", rspValid, 0);

    // R8: every set starts invalid
    for (int i = 0; i < SETS; i++) doLookup(32'(i * 4), "R8");
    @(negedge clk);
    chk("R3", "rspValid idle", rspValid, 0);
    chk("R11", "rspHit idle", rspHit, 0);

    // Plain mode: fill every set, then look each up
    for (int i = 0; i < SETS; i++) doFill(32'h1000_0000 + 32'(i * 4));
    for (int i = 0; i < SETS; i++) doLookup(32'h1000_0000 + 32'(i * 4), "R5");
    // R1: byte offset bits ignored
    for (int i = 0; i < 4; i++) doLookup(32'h1000_0000 + 32'(i * 20) + 32'd3, "R1");
    // R4: same set, different tag
    doLookup(32'h1000_0100, "R4");
    doLookup(32'h2000_0008, "R4");
    // R6: replacement in a direct-mapped set
    doFill(32'h1000_0114);
    doLookup(32'h1000_0014, "R6");
    chk("R6", "old line gone", rspHit, 0);
    doLookup(32'h1000_0114, "R6");
    chk("R6", "new line hits", rspHit, 1);
    // R6: in plain mode, stride-256 addresses collide
    doFill(32'h0000_0000);
    doFill(32'h0000_0100);
    doLookup(32'h0000_0000, "R6");
    doLookup(32'h0000_0100, "R6");

    // R9: fill and lookup in the same cycle
    doLookup(32'h3000_001C, "R9");
    reqValid = 1'b1; reqAddr = 32'h3000_001C;
    fillValid = 1'b1; fillAddr = 32'h3000_001C;
    @(posedge clk); @(negedge clk);
    reqValid = 1'b0; fillValid = 1'b0;
    chk("R9", "same-cycle fill invisible", rspHit, 0);
    mValid[7] = 1'b1; mTag[7] = 24'h30_0000;
    doLookup(32'h3000_001C, "R9");
    chk("R9", "fill visible next", rspHit, 1);

    // R7: flush together with fill; the fill is dropped
    flush = 1'b1; fillValid = 1'b1; fillAddr = 32'h4000_0020;
    @(posedge clk); @(negedge clk);
    flush = 1'b0; fillValid = 1'b0;
    modelFlush();
    doLookup(32'h4000_0020, "R7");
    chk("R7", "dropped fill", rspHit, 0);
    for (int i = 0; i < 8; i++) doLookup(32'h1000_0000 + 32'(i * 4), "R7");

    // Hashed mode: aligned stride-256 objects spread across sets
    hashEn = 1'b1;
    doFlush();
    for (int i = 0; i < SETS; i++) doFill(32'(i) << 8);
    for (int i = 0; i < SETS; i++) begin
      doLookup(32'(i) << 8, "R10");
      chk("R10", "aligned object resident", rspHit, 1);
    end
    // R2: sweep all combinations of low index bits and fold bits
    for (int f = 0; f < 64; f++)
      for (int b = 0; b < 64; b++)
        doLookup((32'(f) << 8) | (32'(b) << 2), "R4");

    // Mixed traffic against the model
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a;
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      a = lcg & 32'h0010_3FFF;
      case (lcg[31:30])
        2'd0:    doFill(a);
        2'd1:    if (lcg[29:26] == 4'd0) doFlush(); else doFill(a);
        default: doLookup(a, "R4");
      endcase
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #(20ns * 200000);
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL R3 watchdog: actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule